// File: doc/BRIEF.md
# Readout Command List Sequencer

This block runs a list of packed bus commands held in a synchronous memory. Each command names a station, a subaddress and a function code. The sequencer fetches each command word in turn and issues one or more bus cycles through a request/acknowledge port. It forwards the words returned by read cycles to a single-cycle event output, and it pulses a completion flag when the read pointer reaches the list length given at start.

A command word may be followed by a modifier word. The modifier turns one command into a loop: repeat, fast repeat, address scan or stop-on-no-Q. It can also place the command behind a wait for a look-at-me signal, or behind a condition on a hit pattern captured earlier in the list. An address-pattern command reads a 16-bit word, and the command after it runs once for each set bit of that word. The words that follow a command are always in this order: repeat count, then hit masks, then write data.

The list memory, the electrical bus timing and the source of the look-at-me signal lie outside the block. It is used by loading the list, setting `list_len` and `lam_limit`, and pulsing `start`.

Top module: `stack_sequencer`

## Requirements
- R1: After reset, and after a reset applied in the middle of a list, `bus_req`, `evt_valid`, `done` and `busy` are all low.
- R2: A command word carries the function in bits 4:0, the subaddress in bits 8:5, the station in bits 13:9 and the long flag in bit 14, and these appear on `bus_f`, `bus_a`, `bus_n` and `bus_long`. A function with bits 4 and 3 both set is a read, and each read cycle emits one event word. That word is all 24 bits when the long flag is set, and the low 16 bits with the upper bits zeroed when it is clear. A function with bit 4 clear runs one cycle and emits nothing.
- R3: A function with bit 4 set and bit 3 clear is a write. It takes two further list lines: the low 16 data bits, then the upper 8 bits in bits 7:0 of the second line. These appear together on `bus_wdata`, and the write emits no event word.
- R4: When the read pointer reaches `list_len`, the sequencer pulses `done` for one cycle with `busy` low in that same cycle. An empty list (`list_len` = 0) completes with no bus cycle.
- R5: Bit 15 of a command word means a modifier word follows. If modifier bit 6 (repeat) or bit 8 (fast) is set, the next line holds a count in bits 10:0, and the command runs exactly that many cycles; a count of 0 gives no cycle. Fast mode also drives `bus_fast` high. Modifier bit 15 has no effect on how many cycles run.
- R6: Modifier bit 5 (address scan) runs the command for the number of cycles given by the count line. The subaddress starts at the command's A field and goes up by one on each cycle, wrapping from 15 to 0.
- R7: Modifier bit 4 (Q-stop) repeats the command while the returned Q is 1, up to the count line. The first cycle that returns Q = 0 ends the command and emits no event word.
- R8: Modifier bit 0 (hit capture) on the first command of the list stores the low 16 bits of that command's read data as the hit word. The hit word is cleared at each start, and the bit has no effect on any later command.
- R9: Modifier bit 3 (hit mode) with a term count k in modifier bits 13:12 reads k mask lines. The command runs if, for at least one mask, every set bit of the mask is also set in the hit word. Otherwise the command is skipped together with all of its lines, and k = 0 always skips.
- R10: Modifier bit 9 (address pattern) makes the command's read data a pattern; that read still emits its event word. The next command then runs one cycle for each set bit of the pattern, in ascending subaddress order, and its own A field is ignored. A pattern of zero runs that next command for no cycle.
- R11: Modifier bit 7 (LAM wait) holds the command until `lam_in` is high. If `lam_in` stays low for `lam_limit` cycles, the command is dropped with no bus cycle and the list continues.
- R12: `bus_req` stays high, with the station, subaddress, function and write data held steady, until `bus_ack` is seen. Modifier bit 1 drives `bus_nos2` high for the cycles of that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin the list at address 0 |
| list_len | input | AW | Number of list lines |
| lam_limit | input | TW | LAM wait limit in clock cycles |
| mem_addr | output | AW | List memory read address |
| mem_rdata | input | 16 | List memory data, one cycle after the address |
| bus_req | output | 1 | Bus cycle request |
| bus_n | output | 5 | Station number |
| bus_a | output | 4 | Subaddress |
| bus_f | output | 5 | Function code |
| bus_long | output | 1 | 24-bit data cycle |
| bus_fast | output | 1 | Fast-mode cycle |
| bus_nos2 | output | 1 | Suppress the second strobe |
| bus_wdata | output | DW | Write data |
| bus_ack | input | 1 | Bus cycle complete |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_q | input | 1 | Q response, valid with bus_ack |
| lam_in | input | 1 | Look-at-me signal for the LAM wait |
| evt_valid | output | 1 | Event word strobe |
| evt_data | output | DW | Event word |
| busy | output | 1 | List in progress |
| done | output | 1 | One-cycle end-of-list pulse |

## Verification
The hardest situations to reach are the ones that depend on state left by an earlier command. Hit conditioning needs a captured hit word, and the address-pattern loop needs a pattern read by the previous command. The bench reaches both by building multi-command lists. Its bus responder returns read data computed from the subaddress, so the hit word and the pattern are known values, and some mask lines are chosen to be subsets of the hit word and others not. Q-stop uses a responder counter that returns Q = 1 a set number of times. Request stability is checked with a responder that can hold off its acknowledge for several cycles.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_NEXT, S_FETCH, S_CMD, S_MOD, S_CNT,
    S_MASK, S_WD0, S_WD1, S_EXEC, S_LAMW, S_BUS
  } seq_state_t;

  // modifier word bit positions
  localparam int M_HIT  = 0;
  localparam int M_NOS2 = 1;
  localparam int M_HM   = 3;
  localparam int M_QS   = 4;
  localparam int M_AS   = 5;
  localparam int M_RM   = 6;
  localparam int M_LAM  = 7;
  localparam int M_FC   = 8;
  localparam int M_AP   = 9;
  localparam int NT_LO  = 12;
  localparam int NT_W   = 2;
  localparam int CNT_W  = 11;
  localparam int WORD_W = 16;
endpackage

// File: rtl/seq_hit_eval.sv
module seq_hit_eval #(
  parameter int NMASK = 3,
  parameter int HW    = 16,
  parameter int CW    = 2
) (
  input  logic [NMASK-1:0][HW-1:0] masks,
  input  logic [CW-1:0]            term_cnt,
  input  logic [HW-1:0]            hit,
  output logic                     ok
);
  logic [NMASK-1:0] term;

  for (genvar i = 0; i < NMASK; i++) begin : g_term
    assign term[i] = (CW'(i) < term_cnt) && ((masks[i] & hit) == masks[i]);
  end

  assign ok = |term;
endmodule

// File: rtl/seq_lam_timer.sv
module seq_lam_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [TW-1:0] limit,
  output logic          expired
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != {TW{1'b1}}) cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt >= limit);

  // R11
  lam_count_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !expired || (limit == '0));
endmodule

// File: rtl/stack_sequencer.sv
module stack_sequencer
  import seq_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 24,
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] list_len,
  input  logic [TW-1:0] lam_limit,
  output logic [AW-1:0] mem_addr,
  input  logic [15:0]   mem_rdata,
  output logic          bus_req,
  output logic [4:0]    bus_n,
  output logic [3:0]    bus_a,
  output logic [4:0]    bus_f,
  output logic          bus_long,
  output logic          bus_fast,
  output logic          bus_nos2,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_q,
  input  logic          lam_in,
  output logic          evt_valid,
  output logic [DW-1:0] evt_data,
  output logic          busy,
  output logic          done
);
  localparam int NMASK = (1 << NT_W) - 1;
  localparam int LW    = CNT_W + 1;
  localparam int HI_W  = DW - WORD_W;

  seq_state_t state, ret;
  logic [AW-1:0]                 ptr;
  logic [WORD_W-1:0]             cmd, modw, wlo, hit, pat;
  logic [CNT_W-1:0]              cnt;
  logic [NMASK-1:0][WORD_W-1:0]  masks;
  logic [NT_W-1:0]               midx;
  logic [LW-1:0]                 left;
  logic [3:0]                    a_cur;
  logic                          pat_pend, pat_mode, first_cmd;
  logic                          hit_ok, lam_expired;

  wire c_rd    = cmd[4] & cmd[3];
  wire c_wr    = cmd[4] & ~cmd[3];
  wire has_cnt = modw[M_RM] | modw[M_AS] | modw[M_QS] | modw[M_FC];
  wire [NT_W-1:0] nt_cnt = modw[NT_LO +: NT_W];
  wire q_stop  = modw[M_QS] & ~bus_q;

  // which line follows, given the modifier and how far parsing has gone
  function automatic seq_state_t pick(input logic [WORD_W-1:0] m,
                                      input logic wr, input logic [1:0] stage);
    if (stage == 2'd0 && (m[M_RM] | m[M_AS] | m[M_QS] | m[M_FC])) return S_CNT;
    if (stage <= 2'd1 && m[M_HM] && m[NT_LO +: NT_W] != '0) return S_MASK;
    if (stage <= 2'd2 && wr) return S_WD0;
    return S_EXEC;
  endfunction

  seq_hit_eval #(.NMASK(NMASK), .HW(WORD_W), .CW(NT_W)) u_hit (
    .masks(masks), .term_cnt(nt_cnt), .hit(hit), .ok(hit_ok)
  );

  seq_lam_timer #(.TW(TW)) u_lam (
    .clk(clk), .rst(rst), .run(state == S_LAMW), .limit(lam_limit),
    .expired(lam_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      ret       <= S_IDLE;
      ptr       <= '0;
      cmd       <= '0;
      modw      <= '0;
      wlo       <= '0;
      hit       <= '0;
      pat       <= '0;
      cnt       <= '0;
      masks     <= '0;
      midx      <= '0;
      left      <= '0;
      a_cur     <= '0;
      pat_pend  <= 1'b0;
      pat_mode  <= 1'b0;
      first_cmd <= 1'b0;
      bus_req   <= 1'b0;
      bus_wdata <= '0;
      evt_valid <= 1'b0;
      evt_data  <= '0;
      busy      <= 1'b0;
      done      <= 1'b0;
    end else begin
      evt_valid <= 1'b0;
      done      <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          ptr      <= '0;
          hit      <= '0;
          pat_pend <= 1'b0;
          busy     <= 1'b1;
          state    <= S_NEXT;
        end
        S_NEXT: begin
          if (ptr >= list_len) begin
            done  <= 1'b1;
            busy  <= 1'b0;
            state <= S_IDLE;
          end else begin
            first_cmd <= (ptr == '0);
            ret       <= S_CMD;
            state     <= S_FETCH;
          end
        end
        S_FETCH: state <= ret;
        S_CMD: begin
          cmd   <= mem_rdata;
          modw  <= '0;
          midx  <= '0;
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          ret   <= mem_rdata[15] ? S_MOD
                 : pick('0, mem_rdata[4] & ~mem_rdata[3], 2'd0);
        end
        S_MOD: begin
          modw  <= mem_rdata;
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          ret   <= pick(mem_rdata, c_wr, 2'd0);
        end
        S_CNT: begin
          cnt   <= mem_rdata[CNT_W-1:0];
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          ret   <= pick(modw, c_wr, 2'd1);
        end
        S_MASK: begin
          masks[midx] <= mem_rdata;
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          if (midx + 1'b1 == nt_cnt) ret <= pick(modw, c_wr, 2'd2);
          else begin
            midx <= midx + 1'b1;
            ret  <= S_MASK;
          end
        end
        S_WD0: begin
          wlo   <= mem_rdata;
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          ret   <= S_WD1;
        end
        S_WD1: begin
          bus_wdata <= {mem_rdata[HI_W-1:0], wlo};
          ptr   <= ptr + 1'b1;
          state <= S_FETCH;
          ret   <= S_EXEC;
        end
        S_EXEC: begin
          pat_pend <= 1'b0;
          pat_mode <= pat_pend;
          if (modw[M_HM] && !hit_ok) begin
            state <= S_NEXT;
          end else begin
            if (pat_pend) begin
              left  <= LW'(16);
              a_cur <= '0;
            end else begin
              left  <= has_cnt ? {1'b0, cnt} : LW'(1);
              a_cur <= cmd[8:5];
            end
            state <= modw[M_LAM] ? S_LAMW : S_BUS;
          end
        end
        S_LAMW: begin
          if (lam_in) state <= S_BUS;
          else if (lam_expired) state <= S_NEXT;
        end
        S_BUS: begin
          if (!bus_req) begin
            if (left == '0) state <= S_NEXT;
            else if (pat_mode && !pat[a_cur]) begin
              left  <= left - 1'b1;
              a_cur <= a_cur + 1'b1;
            end else bus_req <= 1'b1;
          end else if (bus_ack) begin
            bus_req <= 1'b0;
            if (c_rd && !q_stop) begin
              evt_valid <= 1'b1;
              evt_data  <= cmd[14] ? bus_rdata
                                   : {{HI_W{1'b0}}, bus_rdata[WORD_W-1:0]};
            end
            if (c_rd && modw[M_HIT] && first_cmd) hit <= bus_rdata[WORD_W-1:0];
            if (c_rd && modw[M_AP]) begin
              pat      <= bus_rdata[WORD_W-1:0];
              pat_pend <= 1'b1;
            end
            left <= q_stop ? '0 : left - 1'b1;
            if (modw[M_AS] || pat_mode) a_cur <= a_cur + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign mem_addr = ptr;
  assign bus_n    = cmd[13:9];
  assign bus_f    = cmd[4:0];
  assign bus_long = cmd[14];
  assign bus_a    = a_cur;
  assign bus_fast = modw[M_FC];
  assign bus_nos2 = modw[M_NOS2];

  // R12
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_ack |=> bus_req && $stable(bus_a) && $stable(bus_f)
                            && $stable(bus_n) && $stable(bus_wdata));
  // R2
  evt_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    evt_valid |-> $past(bus_req && bus_ack));
  // R11
  lam_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_LAMW |-> !bus_req);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && !bus_req);
  // R9
  zero_terms_skip_chk: assert property (@(posedge clk) disable iff (rst)
    state == S_EXEC && modw[M_HM] && nt_cnt == '0 |=> state == S_NEXT);
endmodule

// File: tb/sim_stack_sequencer.sv
module sim_stack_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 24;
  localparam int TW = 16;

  // {command word, expected event count, expected event word}
  localparam logic [47:0] VEC [0:5] = '{
    {16'h0640, 8'd0, 24'h000000},
    {16'h02BA, 8'd1, 24'h000555},
    {16'h42BA, 8'd1, 24'hC30555},
    {16'h0428, 8'd0, 24'h000000},
    {16'h7FF8, 8'd1, 24'hC30FFF},
    {16'h001B, 8'd1, 24'h000000}
  };

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] list_len = '0;
  logic [TW-1:0] lam_limit = 16'd20;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_rdata = '0;
  logic bus_req, bus_long, bus_fast, bus_nos2;
  logic [4:0] bus_n, bus_f;
  logic [3:0] bus_a;
  logic [DW-1:0] bus_wdata, evt_data;
  logic bus_ack = 1'b0, bus_q = 1'b0, lam_in = 1'b0;
  logic [DW-1:0] bus_rdata = '0;
  logic evt_valid, busy, done;

  logic [15:0] prog [0:63];
  logic [DW-1:0] ev [0:63];
  logic [3:0] cyc_a [0:63];
  int evn, ncyc, q_left, ack_dly, wcnt, viol, checks, fails, cycles;
  logic fast_seen, nos2_seen, prev_req, prev_ack;
  logic [DW-1:0] last_wd;
  logic [4:0] last_f, last_n;
  logic last_l;
  logic [37:0] prev_fields;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_sequencer #(.AW(AW), .DW(DW), .TW(TW)) u0 (
    .clk(clk), .rst(rst), .start(start), .list_len(list_len),
    .lam_limit(lam_limit), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .bus_req(bus_req), .bus_n(bus_n), .bus_a(bus_a), .bus_f(bus_f),
    .bus_long(bus_long), .bus_fast(bus_fast), .bus_nos2(bus_nos2),
    .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
    .bus_q(bus_q), .lam_in(lam_in), .evt_valid(evt_valid),
    .evt_data(evt_data), .busy(busy), .done(done)
  );

  always @(posedge clk) mem_rdata <= prog[mem_addr[5:0]];

  function automatic logic [DW-1:0] rd_val(input logic [3:0] a);
    return 24'hC30000 | {12'h000, a, a, a};
  endfunction

  // bus responder and recorder
  always @(negedge clk) begin
    if (evt_valid && evn < 64) begin ev[evn] = evt_data; evn++; end
    if (bus_req && prev_req && !prev_ack &&
        {bus_n, bus_a, bus_f, bus_wdata} != prev_fields) viol++;
    prev_req = bus_req;
    prev_ack = bus_ack;
    prev_fields = {bus_n, bus_a, bus_f, bus_wdata};
    if (bus_req && !bus_ack) begin
      if (wcnt >= ack_dly) begin
        bus_ack = 1'b1;
        bus_rdata = rd_val(bus_a);
        bus_q = (q_left > 0);
        if (q_left > 0) q_left--;
        wcnt = 0;
        if (ncyc < 64) cyc_a[ncyc] = bus_a;
        ncyc++;
        last_wd = bus_wdata; last_f = bus_f; last_n = bus_n; last_l = bus_long;
        if (bus_fast) fast_seen = 1'b1;
        if (bus_nos2) nos2_seen = 1'b1;
      end else wcnt++;
    end else bus_ack = 1'b0;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_list(input int len);
    int w;
    w = 0;
    evn = 0; ncyc = 0; fast_seen = 1'b0; nos2_seen = 1'b0;
    @(negedge clk);
    list_len = AW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done && w < 5000) begin @(negedge clk); w++; end
    if (!done) chk("R4 list did not finish", 0, 1);
    else chk("R4 busy low with done", {31'd0, busy}, 0);
    @(negedge clk);
  endtask

  initial begin
    checks = 0; fails = 0; evn = 0; ncyc = 0; viol = 0; wcnt = 0;
    ack_dly = 0; q_left = 1000; prev_req = 0; prev_ack = 0; prev_fields = '0;
    for (int i = 0; i < 64; i++) prog[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset outputs", {28'd0, bus_req, evt_valid, done, busy}, 0);

    // R2 vector table of single commands
    for (int i = 0; i < 6; i++) begin
      prog[0] = VEC[i][47:32];
      run_list(1);
      chk("R2 cycles", ncyc, 1);
      chk("R2 events", evn, {24'd0, VEC[i][31:24]});
      if (VEC[i][31:24] != 0) chk("R2 data", {8'd0, ev[0]}, {8'd0, VEC[i][23:0]});
      chk("R2 fields", {17'd0, last_l, last_n, cyc_a[0], last_f},
          {17'd0, VEC[i][46], VEC[i][45:41], VEC[i][40:37], VEC[i][36:32]});
    end

    // R3 write with two data lines
    prog[0] = 16'h0A70; prog[1] = 16'h1234; prog[2] = 16'h0056;
    run_list(3);
    chk("R3 write data", {8'd0, last_wd}, 32'h561234);
    chk("R3 write cycles", ncyc, 1);
    chk("R3 write no event", evn, 0);

    // R5 repeat, count taken from bits 10:0
    prog[0] = 16'h825A; prog[1] = 16'h0040; prog[2] = 16'hF803;
    run_list(3);
    chk("R5 repeat cycles", ncyc, 3);
    chk("R5 repeat events", evn, 3);
    chk("R5 repeat data", {8'd0, ev[2]}, 32'h000222);
    // R5 fast mode
    prog[1] = 16'h0100; prog[2] = 16'h0002;
    run_list(3);
    chk("R5 fast cycles", ncyc, 2);
    chk("R5 fast flag", {31'd0, fast_seen}, 1);
    // R5 count zero
    prog[1] = 16'h0040; prog[2] = 16'h0000;
    run_list(3);
    chk("R5 zero count", ncyc, 0);
    // R5 modifier bit 15 ignored
    prog[1] = 16'h8040; prog[2] = 16'h0002;
    run_list(3);
    chk("R5 bit15 ignored", ncyc, 2);

    // R6 address scan with wrap
    prog[0] = 16'h83DA; prog[1] = 16'h0020; prog[2] = 16'h0003;
    run_list(3);
    chk("R6 scan cycles", ncyc, 3);
    chk("R6 scan addresses", {20'd0, cyc_a[0], cyc_a[1], cyc_a[2]}, 32'h000EF0);

    // R7 Q-stop
    prog[0] = 16'h825A; prog[1] = 16'h0010; prog[2] = 16'h0005;
    q_left = 2;
    run_list(3);
    chk("R7 qstop cycles", ncyc, 3);
    chk("R7 qstop events", evn, 2);
    q_left = 1000;
    prog[2] = 16'h0004;
    run_list(3);
    chk("R7 qstop max count", ncyc, 4);

    // R8 capture + R9 hit conditioning
    prog[0] = 16'h823A; prog[1] = 16'h0001;
    prog[2] = 16'h825A; prog[3] = 16'h2008; prog[4] = 16'h0100; prog[5] = 16'hF000;
    prog[6] = 16'h827A; prog[7] = 16'h1008; prog[8] = 16'h0002;
    prog[9] = 16'h029A;
    run_list(10);
    chk("R9 hit cycles", ncyc, 3);
    chk("R9 hit addresses", {20'd0, cyc_a[0], cyc_a[1], cyc_a[2]}, 32'h000124);
    chk("R8 hit events", evn, 3);
    chk("R9 last event", {8'd0, ev[2]}, 32'h000444);
    // R8 capture ignored on a later command
    prog[0] = 16'h02BA; prog[1] = 16'h823A; prog[2] = 16'h0001;
    prog[3] = 16'h825A; prog[4] = 16'h1008; prog[5] = 16'h0111;
    run_list(6);
    chk("R8 later capture ignored", ncyc, 2);
    // R9 zero term count skips
    prog[0] = 16'h825A; prog[1] = 16'h0008;
    run_list(2);
    chk("R9 zero terms", ncyc, 0);

    // R10 address pattern 0x0666
    prog[0] = 16'h82DA; prog[1] = 16'h0200; prog[2] = 16'h001B;
    run_list(3);
    chk("R10 pattern cycles", ncyc, 7);
    chk("R10 pattern addresses",
        {cyc_a[1], cyc_a[2], cyc_a[3], cyc_a[4], cyc_a[5], cyc_a[6], 8'd0},
        32'h1256_9A00);
    chk("R10 pattern events", evn, 7);
    chk("R10 pattern data", {8'd0, ev[6]}, 32'h000AAA);
    // R10 zero pattern
    prog[0] = 16'h821A; prog[1] = 16'h0200; prog[2] = 16'h02FA;
    run_list(3);
    chk("R10 zero pattern", ncyc, 1);

    // R11 LAM wait timeout then LAM present
    prog[0] = 16'h827A; prog[1] = 16'h0080; prog[2] = 16'h029A;
    lam_in = 1'b0;
    run_list(3);
    chk("R11 timeout cycles", ncyc, 1);
    chk("R11 timeout address", {28'd0, cyc_a[0]}, 4);
    lam_in = 1'b1;
    run_list(3);
    chk("R11 lam cycles", ncyc, 2);
    lam_in = 1'b0;

    // R12 second strobe suppress with slow acknowledge
    ack_dly = 3;
    prog[0] = 16'h825A; prog[1] = 16'h0002;
    run_list(2);
    chk("R12 nos2", {31'd0, nos2_seen}, 1);
    chk("R12 request stable", viol, 0);
    ack_dly = 0;

    // R4 empty list
    run_list(0);
    chk("R4 empty list", ncyc, 0);

    // R1 reset in the middle of a list
    prog[0] = 16'h825A; prog[1] = 16'h0040; prog[2] = 16'h07FF;
    @(negedge clk); list_len = 3; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (30) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 mid-list reset", {28'd0, bus_req, evt_valid, done, busy}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cycles = 0;
    while (cycles < 150000) begin @(posedge clk); cycles++; end
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule